// File: doc/BRIEF.md
# NAND Flash Read-Only Target Pair

This block plays the device side of a small read-only NAND flash array. It watches an 8-bit input data bus and a set of strobes: two active-low chip enables, active-low read and write enables, and active-high command and address latch enables. The strobes are sampled on the system clock, and their edges are found by comparing each sample with the one before. Two independent targets sit behind the strobes, one per chip enable. Each target has its own read mode, address-cycle counter and byte pointer.

A host selects a target and writes a command byte with the command latch high. It then writes up to three address bytes with the address latch high. After that, each read-enable pulse returns one byte from the target's backing store, and the pointer advances after the byte is returned. The page is 528 bytes. The three read modes place the column in the lower half, the upper half or the spare area of that page. The row bytes are scaled by the page size.

The backing store has no storage cells. It is a read-only pattern computed from the target index and the byte location, so a bench can predict every byte. The block never reports busy.

Top module: `nand_rd_target`

## Requirements
- R1: While reset is held, and directly after it, `dout_oe` and `err` are 0 and `dout` is 0x00. Both ready outputs are 0 while reset is held.
- R2: A command byte is taken on the rising edge of `we_n` while `cle` is 1. The byte 0x00 selects column-offset 0, 0x01 selects column-offset 0x100 and 0x50 selects column-offset 0x200. Each of these three clears the address-cycle count. The byte 0xFF returns the target to its idle state.
- R3: The first address byte after a read command sets the pointer to the byte value plus the column offset of the current mode. This replaces the old pointer value.
- R4: The second address byte adds its value times 135168 (528 × 256) to the pointer. The third address byte adds its value times 528. After each addition the pointer is reduced modulo MEM_BYTES (33792 by default).
- R5: On a falling edge of `re_n`, `dout` takes the selected target's byte at the pointer. That byte is `a[7:0] ^ a[15:8] ^ a[23:16] ^ K`, where a is the pointer, K is 0x3C for target 0 and 0xA5 for target 1. On the following rising edge of `re_n` the pointer advances by one, and it wraps from MEM_BYTES-1 to 0.
- R6: `dout_oe` is 1 in the cycle after a read-enable fall while a target is selected. It returns to 0 in the cycle after `re_n` rises.
- R7: `ce1_n` low selects target 0. Otherwise `ce2_n` low selects target 1. With both enables high, strobes have no effect.
- R8: When `cle` and `ale` are both 1 on a write strobe, the byte is treated as a command.
- R9: Three cases set the sticky `err` flag: an unknown command byte, a fourth address byte, and an address byte in the idle state. In each case the byte is otherwise ignored and the pointer does not change. Only reset clears `err`.
- R10: From the first clock after reset, `rdy1` and `rdy2` are both 1 and stay 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Target 0 select, active low, has priority |
| ce2_n | input | 1 | Target 1 select, active low |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address latch enable |
| cle | input | 1 | Command latch enable |
| din | input | 8 | Command or address byte |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| rdy1 | output | 1 | Target 0 ready |
| rdy2 | output | 1 | Target 1 ready |
| err | output | 1 | Sticky protocol error flag |

## Verification
The assertions assume clean strobe behaviour on the inputs:
- Read and write strobes are never low together.
- Each low pulse of a strobe lasts at least one clock.
- The chip enables, latch enables and data stay steady around each strobe edge.

The bench keeps to these rules because every bus access goes through task-driven cycles. Each task changes the inputs on the falling clock edge, holds a strobe low for a full clock period, and restores the latch enables only after the strobe has risen.

// File: rtl/nand_rd_target.sv
module nand_rd_target #(
  parameter int unsigned PAGE_BYTES = 528,
  parameter int unsigned MEM_BYTES  = 33792,
  parameter logic [7:0]  KEY0       = 8'h3C,
  parameter logic [7:0]  KEY1       = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce1_n,
  input  logic       ce2_n,
  input  logic       re_n,
  input  logic       we_n,
  input  logic       ale,
  input  logic       cle,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  output logic       rdy1,
  output logic       rdy2,
  output logic       err
);
  localparam int unsigned PTR_W    = $clog2(MEM_BYTES);
  localparam int unsigned ROW_STEP = PAGE_BYTES * 256;
  localparam int unsigned NTGT     = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_SPARE} mode_e;

  mode_e            mode   [NTGT];
  logic [1:0]       acnt   [NTGT];
  logic [PTR_W-1:0] ptr    [NTGT];
  logic [PTR_W-1:0] ptr_ld [NTGT];
  logic [PTR_W-1:0] ptr_inc[NTGT];
  logic [NTGT-1:0]  hit, err_set;

  logic we_q, re_q, rdy_q, oe_q;
  logic [7:0] dout_q;

  wire we_rise = we_n & ~we_q;
  wire re_fall = ~re_n & re_q;
  wire re_rise = re_n & ~re_q;
  wire sel_any = ~ce1_n | ~ce2_n;
  wire sel_t   = ce1_n;

  assign hit[0] = ~ce1_n;
  assign hit[1] = ce1_n & ~ce2_n;

  wire cmd_ev = we_rise & cle;
  wire adr_ev = we_rise & ~cle & ale;
  wire cmd_ok = (din == 8'hFF) || (din == 8'h00) || (din == 8'h01) || (din == 8'h50);

  function automatic logic [7:0] pattern(input logic t, input logic [PTR_W-1:0] a);
    logic [23:0] w;
    w = 24'(a);
    return w[7:0] ^ w[15:8] ^ w[23:16] ^ (t ? KEY1 : KEY0);
  endfunction

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      logic [31:0] sum;
      case (acnt[t])
        2'd0:    sum = {24'd0, din} | ((mode[t] == ST_HI) ? 32'h100 :
                                       (mode[t] == ST_SPARE) ? 32'h200 : 32'h0);
        2'd1:    sum = 32'(ptr[t]) + 32'(din) * ROW_STEP;
        2'd2:    sum = 32'(ptr[t]) + 32'(din) * PAGE_BYTES;
        default: sum = 32'(ptr[t]);
      endcase
      ptr_ld[t]  = PTR_W'(sum % MEM_BYTES);
      ptr_inc[t] = (32'(ptr[t]) == MEM_BYTES - 1) ? '0 : ptr[t] + 1'b1;
      err_set[t] = hit[t] & ((cmd_ev & ~cmd_ok) |
                             (adr_ev & ((mode[t] == ST_IDLE) | (acnt[t] == 2'd3))));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTGT; t++) begin
        mode[t] <= ST_IDLE;
        acnt[t] <= '0;
        ptr[t]  <= '0;
      end
    end else begin
      for (int t = 0; t < NTGT; t++) begin
        if (hit[t] && cmd_ev && cmd_ok) begin
          case (din)
            8'h00:   mode[t] <= ST_LO;
            8'h01:   mode[t] <= ST_HI;
            8'h50:   mode[t] <= ST_SPARE;
            default: mode[t] <= ST_IDLE;
          endcase
          if (din != 8'hFF) acnt[t] <= '0;
        end else if (hit[t] && adr_ev && !err_set[t]) begin
          ptr[t]  <= ptr_ld[t];
          acnt[t] <= acnt[t] + 2'd1;
        end else if (hit[t] && re_rise) begin
          ptr[t] <= ptr_inc[t];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      re_q   <= 1'b1;
      rdy_q  <= 1'b0;
      oe_q   <= 1'b0;
      dout_q <= '0;
      err    <= 1'b0;
    end else begin
      we_q  <= we_n;
      re_q  <= re_n;
      rdy_q <= 1'b1;
      oe_q  <= sel_any & ~re_n & we_n;
      if (sel_any && re_fall) dout_q <= pattern(sel_t, sel_t ? ptr[1] : ptr[0]);
      if (|err_set) err <= 1'b1;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;
  assign rdy1    = rdy_q;
  assign rdy2    = rdy_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rdy1 && rdy2)); // R10
  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && re_fall && we_n) |=> dout_oe); // R6
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    re_n |=> !dout_oe); // R6
  AST_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ce2_n) |=> ($stable(ptr[0]) && $stable(ptr[1]) && $stable(dout))); // R7

  for (genvar g = 0; g < NTGT; g++) begin : g_chk
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr[g]) < MEM_BYTES); // R4
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && re_rise && we_n) |=>
        (32'(ptr[g]) == ((32'($past(ptr[g])) + 1) % MEM_BYTES))); // R5
  end
endmodule

// File: tb/sim_nand_rd_target.sv
module sim_nand_rd_target;
  localparam int MEM = 33792;
  logic clk = 0, rst_n = 0;
  logic ce1_n = 1, ce2_n = 1, re_n = 1, we_n = 1, ale = 0, cle = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic dout_oe, rdy1, rdy2, err;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_rd_target u0 (.clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .re_n(re_n), .we_n(we_n), .ale(ale), .cle(cle), .din(din),
    .dout(dout), .dout_oe(dout_oe), .rdy1(rdy1), .rdy2(rdy2), .err(err));

  function automatic logic [7:0] expb(int t, int a);
    logic [23:0] w;
    w = 24'(a);
    return w[7:0] ^ w[15:8] ^ w[23:16] ^ (t != 0 ? 8'hA5 : 8'h3C);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ce1_n = 1; ce2_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; din = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic setup(input logic [7:0] cmd, input logic [7:0] a0,
                       input logic [7:0] a1, input logic [7:0] a2);
    wr(1, 0, cmd); wr(0, 1, a0); wr(0, 1, a1); wr(0, 1, a2);
  endtask

  task automatic rd_chk(input string req, input int t, input int a);
    logic [7:0] v; logic o;
    @(negedge clk); re_n = 0;
    @(negedge clk); v = dout; o = dout_oe; re_n = 1;
    @(negedge clk);
    chk(v == expb(t, a), req, v, expb(t, a));
    chk(o == 1'b1, {req, " oe"}, o, 1);
    chk(dout_oe == 1'b0, {req, " oe release"}, dout_oe, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(rdy1 == 0 && rdy2 == 0, "R1 rdy in reset", {rdy1, rdy2}, 0);
    chk(dout_oe == 0 && err == 0 && dout == 0, "R1 reset outputs", {dout_oe, err, dout}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rdy1 && rdy2, "R10 ready", {rdy1, rdy2}, 3);
    chk(dout_oe == 0 && err == 0, "R1 after reset", {dout_oe, err}, 0);
  endtask

  task automatic t_modes();
    ce1_n = 0;
    setup(8'h00, 8'h10, 8'h00, 8'h02);
    rd_chk("R2 R3 R4 R5 mode1", 0, 1072);
    rd_chk("R5 increment", 0, 1073);
    rd_chk("R5 increment", 0, 1074);
    setup(8'h01, 8'h05, 8'h00, 8'h00);
    rd_chk("R2 R3 mode2 column", 0, 261);
    setup(8'h50, 8'h0F, 8'h00, 8'h3F);
    rd_chk("R3 R4 mode3 top", 0, MEM - 1);
    rd_chk("R5 wrap", 0, 0);
    setup(8'h00, 8'h03, 8'h01, 8'h00);
    rd_chk("R4 row modulo", 0, 3);
    chk(err == 0, "R9 no error on legal use", err, 0);
    ce1_n = 1;
  endtask

  task automatic t_select();
    ce2_n = 0;
    setup(8'h00, 8'h20, 8'h00, 8'h01);
    rd_chk("R7 target1", 1, 560);
    ce1_n = 0;
    setup(8'h00, 8'h40, 8'h00, 8'h00);
    ce1_n = 1;
    rd_chk("R7 priority leaves target1", 1, 561);
    ce2_n = 1; ce1_n = 0;
    rd_chk("R7 priority target0", 0, 64);
    ce1_n = 1;
    setup(8'h00, 8'h07, 8'h00, 8'h00);
    @(negedge clk); re_n = 0;
    @(negedge clk);
    chk(dout_oe == 0, "R7 unselected oe", dout_oe, 0);
    re_n = 1;
    @(negedge clk);
    ce1_n = 0;
    rd_chk("R7 unselected ignored", 0, 65);
    chk(err == 0, "R7 unselected no error", err, 0);
    ce1_n = 1;
  endtask

  task automatic t_cle_first();
    ce1_n = 0;
    wr(1, 1, 8'h01);
    wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(0, 1, 8'h00);
    rd_chk("R8 cle over ale", 0, 256);
    chk(err == 0, "R8 no error", err, 0);
    ce1_n = 1;
  endtask

  task automatic t_err_idle();
    do_reset();
    chk(err == 0, "R9 clear by reset", err, 1'b0);
    ce1_n = 0;
    wr(1, 0, 8'hFF);
    wr(0, 1, 8'h11);
    chk(err == 1, "R9 address in idle", err, 1);
    rd_chk("R9 idle address ignored", 0, 0);
    ce1_n = 1;
  endtask

  task automatic t_err_cmd();
    do_reset();
    ce1_n = 0;
    setup(8'h00, 8'h08, 8'h00, 8'h00);
    chk(err == 0, "R9 before bad command", err, 0);
    wr(1, 0, 8'h90);
    chk(err == 1, "R9 unknown command", err, 1);
    rd_chk("R9 unknown command ignored", 0, 8);
    ce1_n = 1;
  endtask

  task automatic t_err_fourth();
    do_reset();
    ce1_n = 0;
    setup(8'h00, 8'h09, 8'h00, 8'h00);
    chk(err == 0, "R9 before fourth byte", err, 0);
    wr(0, 1, 8'h33);
    chk(err == 1, "R9 fourth address", err, 1);
    rd_chk("R9 fourth address ignored", 0, 9);
    setup(8'h00, 8'h02, 8'h00, 8'h00);
    chk(err == 1, "R9 sticky", err, 1);
    ce1_n = 1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_modes();
    t_select();
    t_cle_first();
    t_err_idle();
    t_err_cmd();
    t_err_fourth();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule